// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read/Write Sequencer

This block sits behind a per-chip-select flash window on the system bus. Each bus access is a single read or write of 1 to 8 bytes at any byte address inside a window of up to 128 MiB. The block turns that access into one complete SPI flash transaction. It pulls the chip select of the addressed window low and sends the opcode byte. It then sends the address bytes, most significant first. A read may also get a run of dummy transfers. The data phase follows: on a write the bytes go out, on a read they are collected. The chip select is then released. Every byte crosses a byte-wide shift engine through a request/acknowledge handshake.

The opcode, the address length and the dummy count are taken from a read configuration word or a write configuration word. The word is sampled at the moment each access is accepted. Read data is assembled little-endian, and write data is sent least significant byte first. While a separate user-mode command path holds a chip select, new accesses wait.

Top module: `spi_mmap_seq`

## Requirements
- R1: During an access, only the chip select numbered by `bus_cs` is driven low, and it stays low for every transfer of the access. All chip selects are high whenever no access is in progress.
- R2: The first transfer of every access carries the opcode. The opcode is bits [7:0] of `cfg_rd` for a read and of `cfg_wr` for a write.
- R3: Bits [17:16] of the selected configuration word set the address length. Code 0 sends address bits [23:16], [15:8], [7:0] in that order. Code 1 first sends bits [31:24] of the zero-extended window address and then the same three bytes.
- R4: An address-length code of 2 or 3 sends no address bytes and sets `addr_err`. `addr_err` stays set until reset.
- R5: A read sends (`cfg_rd`[13:12] × 8) >> `cfg_rd`[9:8] dummy transfers after the address, each carrying 0x00.
- R6: A read performs `bus_len_m1`+1 receive transfers, each carrying 0x00. The first received byte lands in `bus_rdata`[7:0] and the next ones in rising byte lanes. Lanes above the access length read as zero.
- R7: A write sends `bus_wdata` bytes, lane 0 first, directly after the address. It never has a dummy phase, whatever the dummy fields of `cfg_wr` hold.
- R8: `bus_len_m1` (0..7) gives 1 to 8 data bytes, and any byte address is accepted, aligned or not.
- R9: While `uma_busy` is high, no access is started: no chip select falls and no transfer is requested.
- R10: `xfer_req` stays high with an unchanged `xfer_tx` until a cycle in which `xfer_ack` is high. Each acknowledged cycle completes exactly one byte.
- R11: `bus_done` is a one-cycle pulse, and the chip select is already high in that cycle. After reset all chip selects are high and `xfer_req`, `bus_done` and `addr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| bus_req | input | 1 | Access request, held until `bus_done` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cs | input | CSW | Window (chip select) index |
| bus_addr | input | WIN_AW | Byte address inside the window |
| bus_len_m1 | input | LEN_W | Data bytes minus one |
| bus_wdata | input | 8*MAX_BYTES | Write data, lane 0 sent first |
| bus_done | output | 1 | Access complete pulse |
| bus_rdata | output | 8*MAX_BYTES | Read data, valid with `bus_done` |
| cfg_rd | input | 32 | Read configuration word |
| cfg_wr | input | 32 | Write configuration word |
| uma_busy | input | 1 | User-mode command holds a chip select |
| xfer_req | output | 1 | Byte transfer request to the shift engine |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Transfer complete |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| cs_n | output | NUM_CS | Active-low chip selects |
| addr_err | output | 1 | Sticky bad-address-length flag |

## Verification
The bench sends the same accesses to a behavioural model and to the block, and it varies the acknowledge latency from byte to byte. The first corner case is the address-length switch at the 3/4 boundary together with the top window address. A design that counts the address bytes wrongly, or sends them least significant first, shows a shifted byte stream. The dummy count is tested with several shift amounts, and writes are sent with non-zero dummy fields; a design that drops the shift or lets a write pick up dummy bytes sends extra transfers. A design that stores read bytes in reverse lanes, or leaves stale upper lanes, fails the 1-, 4- and 8-byte reads. The user-mode stall and the sticky error flag are checked across several accesses.

// File: rtl/spi_mmap_seq_pkg.sv
package spi_mmap_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  // Field positions inside the configuration words
  localparam int unsigned OPC_LSB = 0;
  localparam int unsigned ACC_LSB = 8;
  localparam int unsigned DBW_LSB = 12;
  localparam int unsigned ASZ_LSB = 16;

  // Address byte count for a length code; 0 for the reserved codes
  function automatic logic [2:0] addr_len(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd3;
      2'd1:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Dummy transfer count: width field times eight, shifted by access type
  function automatic logic [4:0] dummy_len(input logic [1:0] bw, input logic [1:0] at);
    logic [4:0] raw;
    raw = {bw, 3'b000};
    return raw >> at;
  endfunction

endpackage

// File: rtl/spi_mmap_seq_csgen.sv
module spi_mmap_seq_csgen #(
  parameter int NUM_CS = 2,
  parameter int CSW    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en,
  input  logic              rel_en,
  input  logic [CSW-1:0]    sel_idx,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_lane
    logic lane_d;
    logic lane_en;

    always_comb begin
      lane_en = 1'b0;
      lane_d  = 1'b1;
      if (sel_en && (sel_idx == CSW'(g))) begin
        lane_en = 1'b1;
        lane_d  = 1'b0;
      end else if (rel_en) begin
        lane_en = 1'b1;
        lane_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cs_n[g] <= 1'b1;
      end else if (lane_en) begin
        cs_n[g] <= lane_d;
      end
    end
  end

endmodule

// File: rtl/spi_mmap_seq_fsm.sv
module spi_mmap_seq_fsm
  import spi_mmap_seq_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_wr,
  input  logic [2:0]       alen,
  input  logic [4:0]       dlen,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             xfer_ack,
  output phase_e           phase,
  output logic [4:0]       cnt,
  output logic             last_ack
);

  phase_e     ph_d;
  phase_e     post_ph;
  logic [4:0] cnt_d;
  logic [4:0] post_cnt;
  logic       step_en;

  // Phase that follows the address (or the opcode when there is no address)
  always_comb begin
    if (!is_wr && (dlen != 5'd0)) begin
      post_ph  = PH_DUMMY;
      post_cnt = dlen - 5'd1;
    end else begin
      post_ph  = PH_DATA;
      post_cnt = 5'd0;
    end
  end

  always_comb begin
    ph_d     = phase;
    cnt_d    = cnt;
    last_ack = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_CMD;
          cnt_d = 5'd0;
        end
      end
      PH_CMD: begin
        if (xfer_ack) begin
          if (alen != 3'd0) begin
            ph_d  = PH_ADDR;
            cnt_d = 5'(alen - 3'd1);
          end else begin
            ph_d  = post_ph;
            cnt_d = post_cnt;
          end
        end
      end
      PH_ADDR: begin
        if (xfer_ack) begin
          if (cnt == 5'd0) begin
            ph_d  = post_ph;
            cnt_d = post_cnt;
          end else begin
            cnt_d = cnt - 5'd1;
          end
        end
      end
      PH_DUMMY: begin
        if (xfer_ack) begin
          if (cnt == 5'd0) begin
            ph_d  = PH_DATA;
            cnt_d = 5'd0;
          end else begin
            cnt_d = cnt - 5'd1;
          end
        end
      end
      PH_DATA: begin
        if (xfer_ack) begin
          if (cnt == 5'(len_m1)) begin
            ph_d     = PH_DONE;
            last_ack = 1'b1;
          end else begin
            cnt_d = cnt + 5'd1;
          end
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign step_en = (ph_d != phase) || (cnt_d != cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= 5'd0;
    end else if (step_en) begin
      phase <= ph_d;
      cnt   <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_mmap_seq_dpath.sv
module spi_mmap_seq_dpath
  import spi_mmap_seq_pkg::*;
#(
  parameter int WIN_AW    = 27,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 3,
  parameter int DW        = 8 * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bus_wr,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [LEN_W-1:0] bus_len_m1,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [31:0]      cfg_rd,
  input  logic [31:0]      cfg_wr,
  input  phase_e           phase,
  input  logic [4:0]       cnt,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx,
  output logic             is_wr,
  output logic [2:0]       alen,
  output logic [4:0]       dlen,
  output logic [LEN_W-1:0] len_m1,
  output logic [7:0]       tx_byte,
  output logic [DW-1:0]    rdata,
  output logic             addr_err
);

  logic [31:0]      cfg_sel;
  logic [7:0]       opc_q;
  logic [1:0]       asz_q;
  logic [1:0]       dbw_q;
  logic [1:0]       acc_q;
  logic [31:0]      addr_q;
  logic [DW-1:0]    wdata_q;
  logic             rd_cap;
  logic             err_set;
  logic [1:0]       abyte;
  logic [LEN_W-1:0] dbyte;
  logic             unused_bits;

  assign cfg_sel = bus_wr ? cfg_wr : cfg_rd;
  assign err_set = start && cfg_sel[ASZ_LSB+1];
  assign rd_cap  = (phase == PH_DATA) && xfer_ack && !is_wr;
  assign abyte   = cnt[1:0];
  assign dbyte   = cnt[LEN_W-1:0];

  assign unused_bits = ^{cfg_rd[31:18], cfg_rd[15:14], cfg_rd[11:10],
                         cfg_wr[31:18], cfg_wr[15:14], cfg_wr[11:10], cnt};

  // Access parameters, captured once per accepted access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_wr   <= 1'b0;
      opc_q   <= 8'd0;
      asz_q   <= 2'd0;
      dbw_q   <= 2'd0;
      acc_q   <= 2'd0;
      addr_q  <= 32'd0;
      wdata_q <= '0;
      len_m1  <= '0;
    end else if (start) begin
      is_wr   <= bus_wr;
      opc_q   <= cfg_sel[OPC_LSB +: 8];
      asz_q   <= cfg_sel[ASZ_LSB +: 2];
      dbw_q   <= cfg_sel[DBW_LSB +: 2];
      acc_q   <= cfg_sel[ACC_LSB +: 2];
      addr_q  <= 32'(bus_addr);
      wdata_q <= bus_wdata;
      len_m1  <= bus_len_m1;
    end
  end

  // Read data assembly, lane 0 first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (start) begin
      rdata <= '0;
    end else if (rd_cap) begin
      rdata[dbyte*8 +: 8] <= xfer_rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_err <= 1'b0;
    end else if (err_set) begin
      addr_err <= 1'b1;
    end
  end

  assign alen = addr_len(asz_q);
  assign dlen = dummy_len(dbw_q, acc_q);

  always_comb begin
    case (phase)
      PH_CMD:  tx_byte = opc_q;
      PH_ADDR: tx_byte = addr_q[abyte*8 +: 8];
      PH_DATA: tx_byte = is_wr ? wdata_q[dbyte*8 +: 8] : 8'h00;
      default: tx_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/spi_mmap_seq.sv
module spi_mmap_seq
  import spi_mmap_seq_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int WIN_AW    = 27,
  parameter int MAX_BYTES = 8,
  localparam int CSW      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int LEN_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int DW       = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [CSW-1:0]    bus_cs,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [LEN_W-1:0]  bus_len_m1,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_done,
  output logic [DW-1:0]     bus_rdata,
  input  logic [31:0]       cfg_rd,
  input  logic [31:0]       cfg_wr,
  input  logic              uma_busy,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic [NUM_CS-1:0] cs_n,
  output logic              addr_err
);

  phase_e           phase;
  logic [4:0]       cnt;
  logic             start;
  logic             last_ack;
  logic             is_wr;
  logic [2:0]       alen;
  logic [4:0]       dlen;
  logic [LEN_W-1:0] len_m1;

  assign start = (phase == PH_IDLE) && bus_req && !uma_busy;

  spi_mmap_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_wr    (is_wr),
    .alen     (alen),
    .dlen     (dlen),
    .len_m1   (len_m1),
    .xfer_ack (xfer_ack),
    .phase    (phase),
    .cnt      (cnt),
    .last_ack (last_ack)
  );

  spi_mmap_seq_dpath #(
    .WIN_AW    (WIN_AW),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .DW        (DW)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_len_m1 (bus_len_m1),
    .bus_wdata  (bus_wdata),
    .cfg_rd     (cfg_rd),
    .cfg_wr     (cfg_wr),
    .phase      (phase),
    .cnt        (cnt),
    .xfer_ack   (xfer_ack),
    .xfer_rx    (xfer_rx),
    .is_wr      (is_wr),
    .alen       (alen),
    .dlen       (dlen),
    .len_m1     (len_m1),
    .tx_byte    (xfer_tx),
    .rdata      (bus_rdata),
    .addr_err   (addr_err)
  );

  spi_mmap_seq_csgen #(.NUM_CS(NUM_CS), .CSW(CSW)) u_cs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_en  (start),
    .rel_en  (last_ack),
    .sel_idx (bus_cs),
    .cs_n    (cs_n)
  );

  assign xfer_req = (phase == PH_CMD) || (phase == PH_ADDR) ||
                    (phase == PH_DUMMY) || (phase == PH_DATA);
  assign bus_done = (phase == PH_DONE);

endmodule

// File: rtl/spi_mmap_seq_chk.sv
module spi_mmap_seq_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uma_busy,
  input logic              xfer_req,
  input logic [7:0]        xfer_tx,
  input logic              xfer_ack,
  input logic              bus_done,
  input logic [NUM_CS-1:0] cs_n,
  input logic              addr_err
);

  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  assert_req_has_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (cs_n != {NUM_CS{1'b1}}));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cs_n) && uma_busy) |=> (&cs_n));

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  assert_done_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> ((&cs_n) && !xfer_req));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);

endmodule

bind spi_mmap_seq spi_mmap_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .uma_busy (uma_busy),
  .xfer_req (xfer_req),
  .xfer_tx  (xfer_tx),
  .xfer_ack (xfer_ack),
  .bus_done (bus_done),
  .cs_n     (cs_n),
  .addr_err (addr_err)
);

// File: tb/sim_spi_mmap_seq.sv
module sim_spi_mmap_seq;

  localparam int NUM_CS = 2;
  localparam int WIN_AW = 27;
  localparam int NB     = 8;

  logic              clk;
  logic              rst_n;
  logic              bus_req;
  logic              bus_wr;
  logic [0:0]        bus_cs;
  logic [WIN_AW-1:0] bus_addr;
  logic [2:0]        bus_len_m1;
  logic [63:0]       bus_wdata;
  logic              bus_done;
  logic [63:0]       bus_rdata;
  logic [31:0]       cfg_rd;
  logic [31:0]       cfg_wr;
  logic              uma_busy;
  logic              xfer_req;
  logic [7:0]        xfer_tx;
  logic              xfer_ack;
  logic [7:0]        xfer_rx;
  logic [NUM_CS-1:0] cs_n;
  logic              addr_err;

  int n_checks;
  int n_fail;
  logic [7:0] act_tx[$];
  logic [7:0] rx_log[$];
  logic [NUM_CS-1:0] exp_cs_n;
  int xfer_total;

  spi_mmap_seq #(.NUM_CS(NUM_CS), .WIN_AW(WIN_AW), .MAX_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_cs(bus_cs), .bus_addr(bus_addr), .bus_len_m1(bus_len_m1),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .uma_busy(uma_busy),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack),
    .xfer_rx(xfer_rx), .cs_n(cs_n), .addr_err(addr_err)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int opc, input int asz, input int dbw, input int acc);
    return 32'(asz) << 16 | 32'(dbw) << 12 | 32'(acc) << 8 | 32'(opc & 255);
  endfunction

  // Shift engine model: variable acknowledge latency, logs every byte
  initial begin
    int wait_ctr;
    xfer_ack   = 1'b0;
    xfer_rx    = 8'h00;
    wait_ctr   = 0;
    xfer_total = 0;
    forever begin
      @(negedge clk);
      if (xfer_ack) begin
        xfer_ack = 1'b0;
      end else if (xfer_req) begin
        if (wait_ctr > 0) begin
          wait_ctr--;
        end else begin
          xfer_rx  = 8'((xfer_total * 37 + 11) & 255);
          xfer_ack = 1'b1;
          act_tx.push_back(xfer_tx);
          rx_log.push_back(xfer_rx);
          chk(cs_n == exp_cs_n, "R1", "chip select during transfer", 64'(cs_n), 64'(exp_cs_n));
          xfer_total++;
          wait_ctr = xfer_total % 3;
        end
      end
    end
  end

  task automatic run_acc(input bit wr, input int cs, input logic [31:0] addr,
                         input int n, input logic [63:0] wd, input int stall);
    logic [31:0] cfg;
    logic [31:0] a32;
    logic [7:0]  exp_q[$];
    logic [63:0] exp_rd;
    int asz, dbw, acc, na, nd, hdr;
    string rq;
    cfg = wr ? cfg_wr : cfg_rd;
    a32 = {5'b0, addr[26:0]};
    asz = int'(cfg[17:16]);
    dbw = int'(cfg[13:12]);
    acc = int'(cfg[9:8]);
    na  = (asz == 0) ? 3 : ((asz == 1) ? 4 : 0);
    nd  = wr ? 0 : ((dbw * 8) >> acc);
    exp_q.push_back(cfg[7:0]);
    for (int i = na - 1; i >= 0; i--) exp_q.push_back(a32[i*8 +: 8]);
    for (int i = 0; i < nd; i++) exp_q.push_back(8'h00);
    for (int i = 0; i < n; i++) exp_q.push_back(wr ? wd[i*8 +: 8] : 8'h00);
    hdr = 1 + na + nd;
    act_tx.delete();
    rx_log.delete();
    exp_cs_n = ~(NUM_CS'(1) << cs);
    @(negedge clk);
    bus_req    = 1'b1;
    bus_wr     = wr;
    bus_cs     = 1'(cs);
    bus_addr   = addr[26:0];
    bus_len_m1 = 3'(n - 1);
    bus_wdata  = wd;
    uma_busy   = (stall > 0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(!xfer_req && (cs_n == '1), "R9", "stalled access started",
          64'({xfer_req, cs_n}), 64'({1'b0, {NUM_CS{1'b1}}}));
    end
    uma_busy = 1'b0;
    do @(negedge clk); while (!bus_done);
    bus_req = 1'b0;
    chk(cs_n == '1, "R11", "chip select at done", 64'(cs_n), 64'({NUM_CS{1'b1}}));
    chk(act_tx.size() == exp_q.size(), "R8", "transfer count",
        64'(act_tx.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < act_tx.size(); i++) begin
      if (i == 0) rq = "R2";
      else if (i <= na) rq = "R3";
      else if (i < hdr) rq = "R5";
      else rq = wr ? "R7" : "R6";
      chk(act_tx[i] == exp_q[i], rq, $sformatf("byte %0d", i), 64'(act_tx[i]), 64'(exp_q[i]));
    end
    if (!wr) begin
      exp_rd = '0;
      for (int i = 0; i < n && (hdr + i) < rx_log.size(); i++) exp_rd[i*8 +: 8] = rx_log[hdr + i];
      chk(bus_rdata == exp_rd, "R6", "read data lanes", bus_rdata, exp_rd);
    end
    @(negedge clk);
    chk(!bus_done, "R11", "done pulse width", 64'(bus_done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R11 actual=%h expected=%h", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    bus_req    = 1'b0;
    bus_wr     = 1'b0;
    bus_cs     = 1'b0;
    bus_addr   = '0;
    bus_len_m1 = '0;
    bus_wdata  = '0;
    uma_busy   = 1'b0;
    exp_cs_n   = '1;
    cfg_rd     = mk_cfg(8'h0B, 0, 1, 0);
    cfg_wr     = mk_cfg(8'h02, 0, 3, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == '1 && !xfer_req && !bus_done && !addr_err, "R11", "reset state",
        64'({cs_n, xfer_req, bus_done, addr_err}), 64'({{NUM_CS{1'b1}}, 3'b000}));

    // R3 three-byte address, R5 eight dummies, four-byte read
    run_acc(1'b0, 0, 32'h0012_3457, 4, 64'd0, 0);
    // R3 four-byte address at the top of the window, R5 shift by one, R8 eight bytes
    cfg_rd = mk_cfg(8'h0C, 1, 2, 1);
    run_acc(1'b0, 1, 32'h07FF_FFFF, 8, 64'd0, 0);
    // R5 no dummy, single unaligned byte
    cfg_rd = mk_cfg(8'h03, 0, 0, 0);
    run_acc(1'b0, 0, 32'h0000_0003, 1, 64'd0, 0);
    // R7 write ignores dummy fields
    run_acc(1'b1, 0, 32'h0055_AA01, 3, 64'h0000_0000_00C3_B2A1, 0);
    cfg_wr = mk_cfg(8'h12, 1, 2, 0);
    run_acc(1'b1, 1, 32'h0401_0207, 8, 64'h8877_6655_4433_2211, 0);
    chk(!addr_err, "R4", "flag before bad code", 64'(addr_err), 64'd0);
    // R4 reserved address code, R5 24>>3 dummies
    cfg_rd = mk_cfg(8'hEB, 2, 3, 3);
    run_acc(1'b0, 1, 32'h0000_1234, 2, 64'd0, 0);
    chk(addr_err, "R4", "flag after bad code", 64'(addr_err), 64'd1);
    // R9 stall behind user-mode command, R5 24>>2 dummies
    cfg_rd = mk_cfg(8'h6B, 0, 3, 2);
    run_acc(1'b0, 0, 32'h0101_0101, 5, 64'd0, 6);
    chk(addr_err, "R4", "flag stays set", 64'(addr_err), 64'd1);
    cfg_wr = mk_cfg(8'h32, 3, 0, 0);
    run_acc(1'b1, 1, 32'h0000_00FF, 2, 64'h0000_0000_0000_5A5A, 3);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule